// File: doc/BRIEF.md
# Dual-Rail Power-Up Sequencer

This block is the control state machine that decides when two switching-regulator rails, a low rail and a high rail, are allowed to run. It watches an active-low shutdown input, two control inputs and a two-bit sequence-mode select. It drives one enable per rail and two status flags, one for shutdown and one for standby, so that downstream logic can clear its own state.

In independent mode each control input owns one rail. In the two ordered modes, control input A is the single master switch. The mode code chooses which rail starts first. The other rail follows after a delay counted in clock cycles. Any turn-off, whether from shutdown, from the master input or from an independent input, reaches the rail enables in the same cycle. Turn-on always passes through a clocked state. The mode is captured only while both rails are idle.

Top module: `seq_dual_rail`

## Requirements
- R1: While `shdn_n` is low, both rail enables are low and `in_shutdown` is high in that same cycle, whatever the mode and control inputs are; `in_standby` is low.
- R2: After `shdn_n` returns high, the block shows standby (`in_standby` high, `in_shutdown` low, rails off) for at least one full cycle before any rail can be enabled.
- R3: Mode codes 2'b00 and 2'b11 are independent. `rail_lo_en` follows `ctl_a` and `rail_hi_en` follows `ctl_b`. Starting from standby, an enable rises one clock after its input. Once a rail is running, input changes reach the enables in the same cycle.
- R4: Mode code 2'b01 starts the low rail first and 2'b10 starts the high rail first. When `ctl_a` goes high in standby, only the first rail is enabled after the next clock.
- R5: In an ordered mode the second rail is enabled exactly D+1 cycles after the first. D is the value on `delay_cycles` at the clock where the first rail is enabled. Later changes to `delay_cycles` have no effect on that start.
- R6: In an ordered mode, `ctl_b` has no effect on either rail enable.
- R7: Deasserting `ctl_a` in an ordered mode turns both rails off in the same cycle and gives standby at the next clock. A new rise of `ctl_a` restarts the full delay.
- R8: A change of `mode_sel` while any rail is enabled has no effect until the block has passed through standby.
- R9: `in_standby` and `in_shutdown` are never high together. Both rails are off whenever either flag is high.
- R10: While `rst_n` is low the block is in shutdown: rails off and `in_shutdown` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| shdn_n | input | 1 | Active-low shutdown request |
| ctl_a | input | 1 | Low-rail control (independent) or master on/off (ordered) |
| ctl_b | input | 1 | High-rail control in independent mode, ignored otherwise |
| mode_sel | input | 2 | 00/11 independent, 01 low rail first, 10 high rail first |
| delay_cycles | input | DLY_W | Second-rail delay D in cycles (actual gap D+1) |
| rail_lo_en | output | 1 | Low rail enable |
| rail_hi_en | output | 1 | High rail enable |
| in_shutdown | output | 1 | Block is in shutdown |
| in_standby | output | 1 | Block is in standby with both rails off |

## Verification
The bench builds the block with DLY_W = 4. With that width every delay value from 0 to 15 can be swept in both ordered modes, and each sweep measures the exact cycle at which the second rail rises. The narrow width also keeps the run short enough to drive every control-input pair under all four mode codes, both into and out of shutdown. It includes all ordered transitions between independent input combinations, a master drop in the middle of a delay, and mode changes made while the rails are running.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_SHDN  = 3'd0,
    ST_STBY  = 3'd1,
    ST_INDEP = 3'd2,
    ST_FIRST = 3'd3,
    ST_BOTH  = 3'd4
  } seq_state_e;

  localparam logic [1:0] MODE_INDEP    = 2'b00;
  localparam logic [1:0] MODE_LO_FIRST = 2'b01;
  localparam logic [1:0] MODE_HI_FIRST = 2'b10;
  localparam logic [1:0] MODE_INDEP_B  = 2'b11;

  function automatic logic mode_is_ordered(input logic [1:0] m);
    return (m == MODE_LO_FIRST) || (m == MODE_HI_FIRST);
  endfunction

endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/seq_mode_reg.sv
module seq_mode_reg #(
  parameter int          MODE_W   = 2,
  parameter logic [1:0]  RST_MODE = 2'b00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [MODE_W-1:0] mode_in,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (load_en) mode_d = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= RST_MODE;
    else        mode_q <= mode_d;
  end
endmodule

// File: rtl/seq_delay_cnt.sv
module seq_delay_cnt #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic             clear,
  input  logic [DLY_W-1:0] load_val,
  output logic             done
);
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             cnt_en;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && !done) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end else if (clear && !done) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
  import seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       shdn_n,
  input  logic       ctl_a,
  input  logic       ctl_b,
  input  logic [1:0] mode_live,
  input  logic       cnt_done,
  output seq_state_e st_q,
  output logic       cnt_load,
  output logic       cnt_run,
  output logic       cnt_clear,
  output logic       mode_load
);
  seq_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (!shdn_n) begin
      st_d = ST_SHDN;
    end else begin
      case (st_q)
        ST_SHDN:  st_d = ST_STBY;
        ST_STBY: begin
          if (mode_is_ordered(mode_live)) begin
            if (ctl_a) st_d = ST_FIRST;
          end else if (ctl_a || ctl_b) begin
            st_d = ST_INDEP;
          end
        end
        ST_INDEP: if (!ctl_a && !ctl_b) st_d = ST_STBY;
        ST_FIRST: begin
          if (!ctl_a)        st_d = ST_STBY;
          else if (cnt_done) st_d = ST_BOTH;
        end
        ST_BOTH:  if (!ctl_a) st_d = ST_STBY;
        default:  st_d = ST_SHDN;
      endcase
    end
  end

  assign cnt_load  = (st_q == ST_STBY) && (st_d == ST_FIRST);
  assign cnt_run   = (st_q == ST_FIRST) && shdn_n && ctl_a;
  assign cnt_clear = (st_q != ST_FIRST);
  assign mode_load = (st_q == ST_STBY) || (st_q == ST_SHDN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_SHDN;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/seq_dual_rail.sv
module seq_dual_rail
  import seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shdn_n,
  input  logic             ctl_a,
  input  logic             ctl_b,
  input  logic [1:0]       mode_sel,
  input  logic [DLY_W-1:0] delay_cycles,
  output logic             rail_lo_en,
  output logic             rail_hi_en,
  output logic             in_shutdown,
  output logic             in_standby
);
  localparam int N_RAIL     = 2;
  localparam int RAIL_IDX_W = $clog2(N_RAIL);

  logic                  rst_n_s;
  seq_state_e            st_q;
  logic                  cnt_load, cnt_run, cnt_clear, cnt_done, mode_load;
  logic [1:0]            mode_q;
  logic [N_RAIL-1:0]     rail_ctl;
  logic [N_RAIL-1:0]     rail_en;
  logic [RAIL_IDX_W-1:0] first_idx;

  seq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  seq_ctrl_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .shdn_n    (shdn_n),
    .ctl_a     (ctl_a),
    .ctl_b     (ctl_b),
    .mode_live (mode_sel),
    .cnt_done  (cnt_done),
    .st_q      (st_q),
    .cnt_load  (cnt_load),
    .cnt_run   (cnt_run),
    .cnt_clear (cnt_clear),
    .mode_load (mode_load)
  );

  seq_mode_reg #(.MODE_W(2), .RST_MODE(MODE_INDEP)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_en (mode_load),
    .mode_in (mode_sel),
    .mode_q  (mode_q)
  );

  seq_delay_cnt #(.DLY_W(DLY_W)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (cnt_load),
    .run      (cnt_run),
    .clear    (cnt_clear),
    .load_val (delay_cycles),
    .done     (cnt_done)
  );

  assign rail_ctl  = {ctl_b, ctl_a};
  assign first_idx = RAIL_IDX_W'(mode_q == MODE_HI_FIRST);

  for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
    logic indep_on;
    logic ord_on;
    assign indep_on   = (st_q == ST_INDEP) && rail_ctl[r];
    assign ord_on     = ctl_a && ((st_q == ST_BOTH) ||
                        ((st_q == ST_FIRST) && (first_idx == RAIL_IDX_W'(r))));
    assign rail_en[r] = shdn_n && (indep_on || ord_on);
  end

  assign rail_lo_en  = rail_en[0];
  assign rail_hi_en  = rail_en[1];
  assign in_shutdown = !shdn_n || (st_q == ST_SHDN);
  assign in_standby  = shdn_n && (st_q == ST_STBY);
endmodule

// File: rtl/seq_dual_rail_chk.sv
module seq_dual_rail_chk (
  input logic clk,
  input logic rst_n,
  input logic shdn_n,
  input logic ctl_a,
  input logic ctl_b,
  input logic rail_lo_en,
  input logic rail_hi_en,
  input logic in_shutdown,
  input logic in_standby
);
  AST_SHDN_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!rail_lo_en && !rail_hi_en)); // R1
  AST_SHDN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (in_shutdown && !in_standby)); // R1
  AST_RISE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rail_lo_en) || $rose(rail_hi_en)) |-> $past(shdn_n)); // R2
  AST_HI_NEEDS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    rail_hi_en |-> (ctl_a || ctl_b)); // R3
  AST_LO_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_a |-> !rail_lo_en); // R7
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_shutdown && in_standby)); // R9
  AST_IDLE_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_shutdown || in_standby) |-> (!rail_lo_en && !rail_hi_en)); // R9
endmodule

bind seq_dual_rail seq_dual_rail_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .shdn_n      (shdn_n),
  .ctl_a       (ctl_a),
  .ctl_b       (ctl_b),
  .rail_lo_en  (rail_lo_en),
  .rail_hi_en  (rail_hi_en),
  .in_shutdown (in_shutdown),
  .in_standby  (in_standby)
);

// File: tb/seq_dual_rail_tb_top.sv
module seq_dual_rail_tb_top;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_n, shdn_n, ctl_a, ctl_b;
  logic [1:0]    mode_sel;
  logic [DW-1:0] dly;
  logic          lo, hi, shd, stb;
  int            n_run = 0;
  int            n_fail = 0;
  bit            finished = 1'b0;

  always #10 clk = ~clk;

  seq_dual_rail #(.DLY_W(DW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .shdn_n       (shdn_n),
    .ctl_a        (ctl_a),
    .ctl_b        (ctl_b),
    .mode_sel     (mode_sel),
    .delay_cycles (dly),
    .rail_lo_en   (lo),
    .rail_hi_en   (hi),
    .in_shutdown  (shd),
    .in_standby   (stb)
  );

  // observed vector {lo, hi, in_shutdown, in_standby}
  function automatic logic [3:0] obs();
    return {lo, hi, shd, stb};
  endfunction

  task automatic chk(input string req, input logic [3:0] exp);
    n_run++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (t=%0t)", req, obs(), exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic go_standby();
    ctl_a = 1'b0; ctl_b = 1'b0; shdn_n = 1'b1;
    tick(); tick();
  endtask

  function automatic logic [3:0] first_vec(input logic [1:0] m);
    return (m == 2'b01) ? 4'b1000 : 4'b0100;
  endfunction

  function automatic bit ordered(input logic [1:0] m);
    return (m == 2'b01) || (m == 2'b10);
  endfunction

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; shdn_n = 1'b1; ctl_a = 1'b0; ctl_b = 1'b0;
    mode_sel = 2'b00; dly = '0;
    #25;
    chk("R10 reset state", 4'b0010);
    @(negedge clk);
    rst_n = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R2 standby after reset", 4'b0001);

    // R1/R2/R4 sweep: every mode and control pair, then shutdown
    dly = 4'd15;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 4; c++) begin
        logic [3:0] exp;
        go_standby();
        mode_sel = 2'(m); ctl_a = c[0]; ctl_b = c[1];
        tick(); tick();
        if (ordered(2'(m))) exp = c[0] ? first_vec(2'(m)) : 4'b0001;
        else                exp = (c != 0) ? {c[0], c[1], 2'b00} : 4'b0001;
        chk(ordered(2'(m)) ? "R4 first rail only" : "R3 independent start", exp);
        shdn_n = 1'b0; settle();
        chk("R1 shutdown same cycle", 4'b0010);
        tick();
        chk("R1 shutdown held", 4'b0010);
        shdn_n = 1'b1; settle();
        chk("R2 still shutdown on release", 4'b0010);
        tick();
        chk("R2 standby before restart", 4'b0001);
      end
    end

    // R3 independent transitions, both independent codes
    for (int mi = 0; mi < 2; mi++) begin
      for (int c1 = 1; c1 < 4; c1++) begin
        for (int c2 = 0; c2 < 4; c2++) begin
          go_standby();
          mode_sel = (mi == 0) ? 2'b00 : 2'b11;
          ctl_a = c1[0]; ctl_b = c1[1];
          settle();
          chk("R3 no rail before clock", 4'b0001);
          tick();
          chk("R3 rails follow inputs", {c1[0], c1[1], 2'b00});
          ctl_a = c2[0]; ctl_b = c2[1]; settle();
          chk("R3 same-cycle change", {c2[0], c2[1], 2'b00});
          tick();
          chk("R3 after change", (c2 == 0) ? 4'b0001 : {c2[0], c2[1], 2'b00});
        end
      end
    end

    // R4/R5/R6 full delay sweep in both ordered modes
    for (int mi = 1; mi < 3; mi++) begin
      for (int d = 0; d < 16; d++) begin
        logic [1:0] m;
        m = 2'(mi);
        go_standby();
        mode_sel = m; dly = 4'(d); ctl_b = d[0]; ctl_a = 1'b1;
        tick();
        dly = ~4'(d);
        chk("R4 first rail", first_vec(m));
        for (int i = 1; i <= d; i++) begin
          ctl_b = ~ctl_b;
          tick();
          chk("R5 R6 second rail waits", first_vec(m));
        end
        ctl_b = ~ctl_b;
        tick();
        chk("R5 second rail at D+1", 4'b1100);
        ctl_b = ~ctl_b; settle();
        chk("R6 ctl_b ignored while both on", 4'b1100);
        ctl_a = 1'b0; settle();
        chk("R7 master drop same cycle", 4'b0000);
        tick();
        chk("R7 standby after drop", 4'b0001);
      end
    end

    // R7 drop mid-delay and restart of full delay
    go_standby();
    mode_sel = 2'b01; dly = 4'd6; ctl_a = 1'b1;
    tick(); tick(); tick(); tick();
    chk("R7 mid-delay first only", 4'b1000);
    ctl_a = 1'b0; settle();
    chk("R7 mid-delay drop", 4'b0000);
    tick();
    chk("R7 mid-delay standby", 4'b0001);
    ctl_a = 1'b1;
    tick();
    for (int i = 1; i <= 6; i++) begin
      tick();
      if (i < 6) chk("R7 restarted delay waits", 4'b1000);
    end
    tick();
    chk("R7 restarted delay completes", 4'b1100);

    // R8 mode change while running
    go_standby();
    mode_sel = 2'b01; dly = 4'd0; ctl_a = 1'b1;
    tick(); tick();
    chk("R8 ordered both up", 4'b1100);
    mode_sel = 2'b00; ctl_b = 1'b0;
    tick(); tick();
    chk("R8 mode change ignored", 4'b1100);
    ctl_a = 1'b0; tick();
    chk("R8 standby", 4'b0001);
    ctl_a = 1'b1; tick();
    chk("R8 new mode independent", 4'b1000);
    mode_sel = 2'b10; ctl_b = 1'b1; settle();
    chk("R8 still independent", 4'b1100);
    ctl_a = 1'b0; settle();
    chk("R8 hi rail stays without master", 4'b0100);
    tick();
    chk("R8 hi rail held", 4'b0100);
    go_standby();
    dly = 4'd3; ctl_a = 1'b1; tick();
    chk("R8 high first after standby", 4'b0100);

    finished = 1'b1;
    report();
    $finish;
  end
endmodule